// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, cycle by cycle, which hardware thread feeds the next instruction into a pipeline shared by several threads. It keeps one program counter per thread, presents the counter of the chosen thread, and drives a one-hot select for that thread's register-file context. The number of threads, the counter width and the instruction step are parameters.

Two scheduling modes are offered. In interleaved mode the choice rotates every clock over the threads that can issue, and passes over any that are stalled. In switch-on-miss mode one thread owns the pipeline until it reports an expensive miss. The block then flushes the pipeline, holds it frozen until the pipeline reports it is empty, and hands issue to the next thread that can run. A thread that has had an expensive miss stays out of the selection until its ready flag rises again.

Top module: `thread_select_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, `selValid`, `flush` and `freeze` are 0, `selTid` is 0 and each thread's counter holds its slice of `resetVec` (thread t at bits t*PC_W upward). The first issue after reset goes to thread 0 if thread 0 is eligible.
- R2: A thread's counter grows by INSTR_BYTES (4) on each clock edge where that thread is issued (`selValid`=1 with its ID), and at no other time. `pcOut` shows the counter of `selTid`. `ctxSel` has only bit `selTid` set when `selValid`=1, and is all zeros otherwise.
- R3: With `coarseMode`=0, the issued thread is the first eligible thread after the last issued one, taken in ascending order with wrap-around. A thread is eligible when its `threadReady` bit is 1 and it has no pending miss. All outputs are registered: the inputs of a cycle determine the outputs after the next rising edge.
- R4: When no thread is eligible, `selValid` is 0 and the rotation position is kept, so the next grant continues after the last thread that was issued.
- R5: With `coarseMode`=1 and no miss, the current thread issues whenever it is eligible. When it is not ready, the block issues a bubble and does not change thread.
- R6: A miss tagged with the current thread in switch-on-miss mode gives `selValid`=0 and a one-cycle `flush` pulse after the next edge. `freeze` then stays 1 and `selValid` stays 0 until an edge where `pipeDrained` has been seen since the miss and some thread is eligible.
- R7: After such a switch, the new thread is the first eligible thread after the old one, in ascending order with wrap-around. The old thread is the last candidate.
- R8: A miss on thread t makes thread t ineligible. Thread t becomes eligible again one cycle after its `threadReady` bit rises. In the cycle where the bit rises, it is still not eligible.
- R9: In switch-on-miss mode, a miss tagged with a thread other than the current one causes no switch, no flush and no freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| coarseMode | input | 1 | 0 = interleave every cycle, 1 = switch only on miss |
| threadReady | input | NUM_THREADS | Per-thread ready flag (0 = stalled) |
| missValid | input | 1 | Expensive miss event this cycle |
| missTid | input | TID_W | Thread that took the miss |
| pipeDrained | input | 1 | Pipeline is empty |
| resetVec | input | NUM_THREADS*PC_W | Per-thread counter start values |
| selValid | output | 1 | An instruction is issued this cycle |
| selTid | output | TID_W | Issued thread |
| pcOut | output | PC_W | Counter of the issued thread |
| ctxSel | output | NUM_THREADS | One-hot register context select |
| flush | output | 1 | One-cycle pipeline flush on a switch |
| freeze | output | 1 | Pipeline held while draining |

## Verification
The embedded properties check the following on every cycle:
- an issued thread was ready on the previous edge;
- the thread does not change between two consecutive issues in switch-on-miss mode;
- a miss on the current thread leads to a frozen bubble and a flush that lasts one cycle;
- the context select is one-hot exactly when an instruction issues;
- back-to-back issues of one thread step its counter.

Only the bench scenarios can show the rotation order, the choice of the next thread after a drain, the one-cycle delay before a missed thread becomes eligible again, and that a miss on a non-current thread has no effect. The bench checks these against a reference model that follows the requirements, under directed sequences and long random runs.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  // Widest thread ID the strobe bundle can carry (up to 64 threads)
  localparam int TSEL_TID_MAX_W = 6;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } coarseState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic                      issueValid;
    logic [TSEL_TID_MAX_W-1:0] issueTid;
  } ctrlStrb_t;

endpackage

// File: rtl/tsel_pick.sv
// Round-robin search: first set bit of eligMask after basePtr, with wrap.
// With startSelf the search starts at basePtr itself.
module tsel_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] eligMask,
  input  logic [TID_W-1:0]       basePtr,
  input  logic                   startSelf,
  output logic                   found,
  output logic [TID_W-1:0]       pickTid
);

  always_comb begin
    found   = 1'b0;
    pickTid = basePtr;
    // Walk from the farthest offset to the nearest so the nearest wins
    for (int k = NUM_THREADS; k >= 1; k--) begin
      int idx;
      idx = (int'(basePtr) + k - (startSelf ? 1 : 0)) % NUM_THREADS;
      if (eligMask[idx]) begin
        found   = 1'b1;
        pickTid = idx[TID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coarseMode,
  input  logic [NUM_THREADS-1:0] threadReady,
  input  logic                   missValid,
  input  logic [TID_W-1:0]       missTid,
  input  logic                   pipeDrained,
  output ctrlStrb_t              strb,
  output logic                   flush,
  output logic                   freeze
);

  coarseState_e          state;
  logic [TID_W-1:0]      curTid;      // last issued / owning thread
  logic                  started;
  logic                  selValid;
  logic [TID_W-1:0]      selTid;
  logic                  flushR;
  logic                  drainedSeen;
  logic [NUM_THREADS-1:0] missPend;
  logic [NUM_THREADS-1:0] readyPrev;

  logic [NUM_THREADS-1:0] eligMask;
  logic                   startSelf;
  logic                   pickFound;
  logic [TID_W-1:0]       pickTid;
  logic                   missCur;

  assign eligMask  = threadReady & ~missPend;
  assign startSelf = !started && !coarseMode;
  assign missCur   = missValid && (missTid == curTid);

  tsel_pick #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) i_pick (
    .eligMask  (eligMask),
    .basePtr   (curTid),
    .startSelf (startSelf),
    .found     (pickFound),
    .pickTid   (pickTid)
  );

  // Pending-miss tracking: set by a miss, cleared on the ready rise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      missPend  <= '0;
      readyPrev <= '0;
    end else begin
      readyPrev <= threadReady;
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (missValid && (missTid == t[TID_W-1:0]))
          missPend[t] <= 1'b1;
        else if (threadReady[t] && !readyPrev[t])
          missPend[t] <= 1'b0;
      end
    end
  end

  // Selection and switch sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_RUN;
      curTid      <= '0;
      started     <= 1'b0;
      selValid    <= 1'b0;
      selTid      <= '0;
      flushR      <= 1'b0;
      drainedSeen <= 1'b0;
    end else begin
      flushR   <= 1'b0;
      selValid <= 1'b0;
      if (!coarseMode) begin
        state <= ST_RUN;
        if (pickFound) begin
          selValid <= 1'b1;
          selTid   <= pickTid;
          curTid   <= pickTid;
          started  <= 1'b1;
        end
      end else if (state == ST_RUN) begin
        if (missCur) begin
          state       <= ST_DRAIN;
          flushR      <= 1'b1;
          drainedSeen <= 1'b0;
        end else if (eligMask[curTid]) begin
          selValid <= 1'b1;
          selTid   <= curTid;
          started  <= 1'b1;
        end
      end else begin
        if (pipeDrained) drainedSeen <= 1'b1;
        if ((drainedSeen || pipeDrained) && pickFound) begin
          state    <= ST_RUN;
          selValid <= 1'b1;
          selTid   <= pickTid;
          curTid   <= pickTid;
          started  <= 1'b1;
        end
      end
    end
  end

  assign strb.issueValid = selValid;
  assign strb.issueTid   = TSEL_TID_MAX_W'(selTid);
  assign flush           = flushR;
  assign freeze          = (state == ST_DRAIN);

  // An issued thread was ready at the edge that chose it (R3)
  p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> readyPrev[selTid]);

  // Switch-on-miss: back-to-back issues keep the same thread (R5)
  p_coarse_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && $past(selValid) && coarseMode && $past(coarseMode))
      |-> (selTid == $past(selTid)));

  // A miss on the owner leads to a frozen bubble with a flush (R6)
  p_miss_bubble_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && state == ST_RUN && missCur) |=> (freeze && flush && !selValid));

  // The flush lasts one cycle (R6)
  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush);

endmodule

// File: rtl/tsel_path.sv
module tsel_path
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrb_t                   strb,
  input  logic [NUM_THREADS*PC_W-1:0] resetVec,
  output logic [PC_W-1:0]             pcOut,
  output logic [NUM_THREADS-1:0]      ctxSel
);

  logic [PC_W-1:0] pcReg [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rstN)
        pcReg[t] <= resetVec[t*PC_W +: PC_W];
      else if (strb.issueValid && (strb.issueTid == TSEL_TID_MAX_W'(t)))
        pcReg[t] <= pcReg[t] + PC_W'(INSTR_BYTES);
    end
  end

  assign pcOut = pcReg[strb.issueTid];

  always_comb begin
    ctxSel = '0;
    if (strb.issueValid) ctxSel[strb.issueTid] = 1'b1;
  end

  // Context select is one-hot exactly on issue (R2)
  p_ctx_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueValid ? ($countones(ctxSel) == 1) : (ctxSel == '0));

  // Consecutive issues of one thread step its counter (R2)
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issueValid && $past(strb.issueValid) && strb.issueTid == $past(strb.issueTid))
      |-> (pcOut == $past(pcOut) + PC_W'(INSTR_BYTES)));

endmodule

// File: rtl/thread_select_ctrl.sv
module thread_select_ctrl
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        coarseMode,
  input  logic [NUM_THREADS-1:0]      threadReady,
  input  logic                        missValid,
  input  logic [TID_W-1:0]            missTid,
  input  logic                        pipeDrained,
  input  logic [NUM_THREADS*PC_W-1:0] resetVec,
  output logic                        selValid,
  output logic [TID_W-1:0]            selTid,
  output logic [PC_W-1:0]             pcOut,
  output logic [NUM_THREADS-1:0]      ctxSel,
  output logic                        flush,
  output logic                        freeze
);

  ctrlStrb_t strb;

  tsel_ctrl #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .coarseMode  (coarseMode),
    .threadReady (threadReady),
    .missValid   (missValid),
    .missTid     (missTid),
    .pipeDrained (pipeDrained),
    .strb        (strb),
    .flush       (flush),
    .freeze      (freeze)
  );

  tsel_path #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .resetVec (resetVec),
    .pcOut    (pcOut),
    .ctxSel   (ctxSel)
  );

  assign selValid = strb.issueValid;
  assign selTid   = strb.issueTid[TID_W-1:0];

endmodule

// File: tb/test_thread_select_ctrl.sv
module test_thread_select_ctrl;

  localparam int NT = 4;
  localparam int PW = 32;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          coarseMode = 1'b0;
  logic [NT-1:0] threadReady = '0;
  logic          missValid = 1'b0;
  logic [TW-1:0] missTid = '0;
  logic          pipeDrained = 1'b0;
  logic [NT*PW-1:0] resetVec;
  logic          selValid;
  logic [TW-1:0] selTid;
  logic [PW-1:0] pcOut;
  logic [NT-1:0] ctxSel;
  logic          flush;
  logic          freeze;

  always #4 clk = ~clk;  // 125 MHz

  for (genvar t = 0; t < NT; t++) begin : g_vec
    assign resetVec[t*PW +: PW] = 32'h1000 * (t + 1);
  end

  thread_select_ctrl #(.NUM_THREADS(NT), .PC_W(PW), .INSTR_BYTES(4)) i_thread_select_ctrl (
    .clk(clk), .rstN(rstN), .coarseMode(coarseMode), .threadReady(threadReady),
    .missValid(missValid), .missTid(missTid), .pipeDrained(pipeDrained),
    .resetVec(resetVec), .selValid(selValid), .selTid(selTid), .pcOut(pcOut),
    .ctxSel(ctxSel), .flush(flush), .freeze(freeze)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Reference model state
  int         mPtr = 0;
  bit         mStarted = 0;
  bit         mDrain = 0;
  bit         mDrained = 0;
  bit [NT-1:0] mPend = '0;
  bit [NT-1:0] mPrev = '0;
  logic [PW-1:0] mPc [NT];
  bit         eValid = 0;
  int         eTid = 0;
  bit         eFlush = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pickAfter(input int base, input bit self, input bit [NT-1:0] m);
    for (int k = 0; k < NT; k++) begin
      int idx;
      idx = (base + k + (self ? 0 : 1)) % NT;
      if (m[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic step(input bit mode, input logic [NT-1:0] rdy, input bit mv,
                      input int mt, input bit dr, input string tag);
    bit [NT-1:0] elig;
    int p;
    string vt;
    @(negedge clk);
    coarseMode  = mode;
    threadReady = rdy;
    missValid   = mv;
    missTid     = mt[TW-1:0];
    pipeDrained = dr;
    if (eValid) mPc[eTid] = mPc[eTid] + 4;
    elig   = rdy & ~mPend;
    eFlush = 0;
    eValid = 0;
    if (!mode) begin
      mDrain = 0;
      p = pickAfter(mPtr, !mStarted, elig);
      if (p >= 0) begin eValid = 1; eTid = p; mPtr = p; mStarted = 1; end
    end else if (!mDrain) begin
      if (mv && mt == mPtr) begin mDrain = 1; eFlush = 1; mDrained = 0; end
      else if (elig[mPtr]) begin eValid = 1; eTid = mPtr; mStarted = 1; end
    end else begin
      p = pickAfter(mPtr, 0, elig);
      if ((mDrained || dr) && p >= 0) begin
        mDrain = 0; eValid = 1; eTid = p; mPtr = p; mStarted = 1;
      end
      if (dr) mDrained = 1;
    end
    for (int t = 0; t < NT; t++) begin
      if (mv && mt == t) mPend[t] = 1;
      else if (rdy[t] && !mPrev[t]) mPend[t] = 0;
    end
    mPrev = rdy;
    vt = (tag != "") ? tag : (mode ? (mDrain ? "R6" : "R5") : "R3");
    @(posedge clk);
    #1;
    check({vt, " valid"}, 32'(selValid), 32'(eValid));
    if (eValid) begin
      check({vt, " tid"}, 32'(selTid), 32'(eTid));
      check("R2 pc", pcOut, mPc[eTid]);
      check("R2 ctx", 32'(ctxSel), 32'(1 << eTid));
    end else begin
      check("R2 ctx idle", 32'(ctxSel), 32'h0);
    end
    check("R6 flush", 32'(flush), 32'(eFlush));
    check("R6 freeze", 32'(freeze), 32'(mDrain));
  endtask

  int stallCnt [NT];

  initial begin
    void'($urandom(32'h0005eed1));
    for (int t = 0; t < NT; t++) begin mPc[t] = 32'h1000 * (t + 1); stallCnt[t] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 32'(selValid), 32'h0);
    check("R1 reset tid", 32'(selTid), 32'h0);
    check("R1 reset pc", pcOut, 32'h1000);
    check("R1 reset flush", 32'(flush | freeze), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Interleaved rotation, first grant is thread 0
    step(0, 4'b1111, 0, 0, 0, "R1");
    check("R1 first tid", 32'(selTid), 32'h0);
    step(0, 4'b1111, 0, 0, 0, "R3");
    step(0, 4'b1111, 0, 0, 0, "R3");
    step(0, 4'b1111, 0, 0, 0, "R3");
    step(0, 4'b1111, 0, 0, 0, "R3");
    check("R3 wrap tid", 32'(selTid), 32'h0);
    // Thread 2 stalled is skipped
    step(0, 4'b1011, 0, 0, 0, "R3");
    step(0, 4'b1011, 0, 0, 0, "R3");
    check("R3 skip tid", 32'(selTid), 32'h3);
    // All stalled: bubble, position kept
    step(0, 4'b0000, 0, 0, 0, "R4");
    check("R4 bubble", 32'(selValid), 32'h0);
    step(0, 4'b0000, 0, 0, 0, "R4");
    step(0, 4'b1111, 0, 0, 0, "R4");
    check("R4 resume tid", 32'(selTid), 32'h0);
    // Miss on thread 1, then its ready rises
    step(0, 4'b1101, 1, 1, 0, "R8");
    check("R8 pick during miss", 32'(selTid), 32'h2);
    step(0, 4'b0010, 0, 0, 0, "R8");
    check("R8 rise cycle blocked", 32'(selValid), 32'h0);
    step(0, 4'b0010, 0, 0, 0, "R8");
    check("R8 eligible next", 32'(selValid && selTid == 1), 32'h1);
    // Switch-on-miss: owner keeps issuing
    step(1, 4'b1111, 0, 0, 0, "R5");
    step(1, 4'b1111, 0, 0, 0, "R5");
    check("R5 hold tid", 32'(selTid), 32'h1);
    step(1, 4'b1101, 0, 0, 0, "R5");
    check("R5 short stall bubble", 32'(selValid | freeze), 32'h0);
    step(1, 4'b1111, 0, 0, 0, "R5");
    check("R5 same after stall", 32'(selTid), 32'h1);
    // Miss on another thread: no switch
    step(1, 4'b0111, 1, 3, 0, "R9");
    check("R9 no switch", 32'(selValid && selTid == 1 && !flush && !freeze), 32'h1);
    step(1, 4'b0111, 0, 0, 0, "R9");
    // Miss on owner: flush, freeze, drain, then next eligible
    step(1, 4'b0001, 1, 1, 0, "R6");
    check("R6 flush pulse", 32'(flush && freeze && !selValid), 32'h1);
    step(1, 4'b0001, 0, 0, 0, "R6");
    check("R6 frozen", 32'(freeze && !flush && !selValid), 32'h1);
    step(1, 4'b0001, 0, 0, 0, "R6");
    step(1, 4'b0001, 0, 0, 1, "R7");
    check("R7 next thread", 32'(selValid && selTid == 0 && !freeze), 32'h1);

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      bit mode;
      logic [NT-1:0] rdy;
      bit mv;
      int mt;
      mode = coarseMode;
      if ($urandom_range(99) == 0) mode = !mode;
      mv = ($urandom_range(19) == 0);
      mt = $urandom_range(NT - 1);
      if (mv) stallCnt[mt] = $urandom_range(10, 3);
      for (int t = 0; t < NT; t++) begin
        if (stallCnt[t] > 0) begin
          rdy[t] = 1'b0;
          if (!(mv && mt == t)) stallCnt[t]--;
        end else begin
          rdy[t] = ($urandom_range(99) < 85);
        end
      end
      step(mode, rdy, mv, mt, ($urandom_range(9) < 3), "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule